// File: doc/BRIEF.md
# Small TLB-Backed Address Translator

This block maps a 14-bit virtual address to a 12-bit physical address using 64-byte pages. Each request is first looked up in a small 4-set, 4-way translation cache. If no way matches, the block reads a 256-entry page table that it holds in its own registers. When that entry is valid, the translation is written back into the cache. When it is not, the response reports a page fault and nothing else is done about it.

Requests enter through a valid/ready handshake and answers leave through a second one. An answer carries the physical address, a flag that says whether the translation cache supplied it, and a fault flag. A separate write port loads page-table entries. A flush input empties the translation cache. Page-table writes never reach the translation cache by themselves, so software must flush after changing a mapping.

Top module: `vtrans_top`

## Requirements
- R1: The VPN is vaddr[13:6]; its low 2 bits select the cache set and its upper 6 bits form the tag. A successful answer has rsp_paddr = {PPN, vaddr[5:0]}, with the 6-bit offset passed through unchanged.
- R2: A request that hits a valid, tag-matching way gives rsp_valid in the cycle after acceptance, with rsp_tlb_hit=1, rsp_fault=0 and the cached PPN.
- R3: A request that misses reads the page table at its VPN and gives rsp_valid two cycles after acceptance, with rsp_tlb_hit=0.
- R4: A miss whose page-table entry is invalid answers with rsp_fault=1, rsp_tlb_hit=0 and rsp_paddr=0, and installs nothing in the cache, so a repeat of the same request faults again.
- R5: A miss whose page-table entry is valid installs the translation, so the next request to that VPN hits.
- R6: An install uses the lowest-numbered invalid way of the set. If all four ways are valid, it evicts the way named by that set's 2-bit round-robin pointer. The pointer is 0 after reset, advances by one (wrapping) on each eviction, and is kept across flushes.
- R7: A flush pulse invalidates every cache entry within one cycle, so the next request misses. A flush in the same cycle as an install cancels the install.
- R8: A page-table write leaves cached translations untouched. A cached VPN keeps its old PPN until a flush.
- R9: req_ready is 1 only while no translation is in progress or waiting to be taken. No request is accepted while busy.
- R10: While rsp_valid=1 and rsp_ready=0, the answer stays valid and all its fields stay stable.
- R11: After reset, req_ready=1, rsp_valid=0, the cache is empty and every page-table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 14 | Virtual address to translate |
| rsp_valid | output | 1 | Answer present |
| rsp_ready | input | 1 | Consumer takes the answer |
| rsp_paddr | output | 12 | Physical address (0 on fault) |
| rsp_tlb_hit | output | 1 | Answer came from the translation cache |
| rsp_fault | output | 1 | Page-table entry was invalid |
| pt_we | input | 1 | Page-table write strobe |
| pt_vpn | input | 8 | Page-table entry to write |
| pt_ppn | input | 6 | PPN to store |
| pt_valid | input | 1 | Valid bit to store |
| flush | input | 1 | Invalidate the whole translation cache |

## Verification
The assertions check the following on every cycle:
- a held answer stays unchanged;
- no request is taken while busy;
- a faulting answer is clean;
- the page offset passes through;
- at most one way matches;
- a flush empties the cache;
- the round-robin pointer moves only on evictions;
- each kind of answer arrives with its own latency.

Only the bench scenarios can show the rest: the PPN a given walk returns, that a fault leaves nothing cached, that a stale mapping survives a page-table write until a flush, and the exact sequence of victims once a set is full.

// File: rtl/vt_pkg.sv
package vt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_RESP = 2'd2
  } vt_state_e;
endpackage

// File: rtl/vt_ptab.sv
module vt_ptab #(
  parameter int VPN_W = 8,
  parameter int PPN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_valid,
  input  logic [VPN_W-1:0] rd_vpn,
  output logic [PPN_W-1:0] rd_ppn,
  output logic             rd_valid
);
  localparam int DEPTH = 1 << VPN_W;

  logic [DEPTH-1:0] vld_q, vld_d;
  logic [PPN_W-1:0] ppn_q [DEPTH];

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_vpn] = wr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) ppn_q[wr_vpn] <= wr_ppn;
  end

  assign rd_ppn   = ppn_q[rd_vpn];
  assign rd_valid = vld_q[rd_vpn];

  // A write takes effect on the next edge only
  AST_PT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_vpn)] == $past(wr_valid)); // R4
endmodule

// File: rtl/vt_tlb.sv
module vt_tlb #(
  parameter int VPN_W = 8,
  parameter int PPN_W = 6,
  parameter int SETS  = 4,
  parameter int WAYS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][WAYS];
  logic [SETS-1:0][WAYS-1:0]  vld_q, vld_d;
  logic [SETS-1:0][WAY_W-1:0] rr_q, rr_d;

  logic [IDX_W-1:0] lk_set, f_set;
  logic [TAG_W-1:0] lk_tag, f_tag;
  logic [WAYS-1:0]  match;
  logic [WAY_W-1:0] victim;
  logic             set_full;
  logic             do_fill;

  assign lk_set = lk_vpn[IDX_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
  assign f_set  = fill_vpn[IDX_W-1:0];
  assign f_tag  = fill_vpn[VPN_W-1:IDX_W];

  // Per-way compare
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  always_comb begin
    lk_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) lk_ppn = lk_ppn | ppn_q[lk_set][w];
    end
  end
  assign lk_hit = |match;

  // Victim: lowest invalid way, else the set's round-robin pointer
  assign set_full = &vld_q[f_set];
  always_comb begin
    victim = rr_q[f_set];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[f_set][w]) victim = WAY_W'(w);
    end
  end

  assign do_fill = fill_en && !flush;

  always_comb begin
    vld_d = vld_q;
    rr_d  = rr_q;
    if (flush) begin
      vld_d = '0;
    end else if (fill_en) begin
      vld_d[f_set][victim] = 1'b1;
      if (set_full) begin
        if (rr_q[f_set] == WAY_W'(WAYS - 1)) rr_d[f_set] = '0;
        else                                 rr_d[f_set] = rr_q[f_set] + WAY_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[f_set][victim] <= f_tag;
      ppn_q[f_set][victim] <= fill_ppn;
    end
  end

  AST_ONE_WAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0)); // R7
  AST_RR_ONLY_ON_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_fill && set_full) |=> $stable(rr_q)); // R6
  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    do_fill |=> vld_q[$past(f_set)][$past(victim)]); // R5
endmodule

// File: rtl/vt_ctrl.sv
module vt_ctrl
  import vt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic rsp_ready,
  input  logic lk_hit,
  output logic req_ready,
  output logic rsp_valid,
  output logic accept,
  output logic acc_hit,
  output logic walk_done
);
  vt_state_e st_q, st_d;

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_RESP);
  assign accept    = req_valid && req_ready;
  assign acc_hit   = accept && lk_hit;
  assign walk_done = (st_q == ST_WALK);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = lk_hit ? ST_RESP : ST_WALK;
      ST_WALK: st_d = ST_RESP;
      ST_RESP: if (rsp_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || walk_done) |-> !req_ready); // R9
  AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> rsp_valid); // R2
  AST_MISS_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !lk_hit) |=> (walk_done && !rsp_valid)); // R3
  AST_WALK_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> rsp_valid); // R3
endmodule

// File: rtl/vtrans_top.sv
module vtrans_top #(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int SETS  = 4,
  parameter int WAYS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VA_W-1:0]         req_vaddr,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [PA_W-1:0]         rsp_paddr,
  output logic                    rsp_tlb_hit,
  output logic                    rsp_fault,
  input  logic                    pt_we,
  input  logic [VA_W-OFF_W-1:0]   pt_vpn,
  input  logic [PA_W-OFF_W-1:0]   pt_ppn,
  input  logic                    pt_valid,
  input  logic                    flush
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  logic             accept, acc_hit, walk_done;
  logic             lk_hit, pt_ok;
  logic [PPN_W-1:0] lk_ppn, pt_rd_ppn;
  logic [VA_W-1:0]  vaddr_q, vaddr_d;
  logic [PA_W-1:0]  paddr_q, paddr_d;
  logic             hit_q, hit_d, fault_q, fault_d;
  logic [VPN_W-1:0] walk_vpn;

  assign walk_vpn = vaddr_q[VA_W-1:OFF_W];

  vt_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rsp_ready (rsp_ready),
    .lk_hit    (lk_hit),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .accept    (accept),
    .acc_hit   (acc_hit),
    .walk_done (walk_done)
  );

  vt_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .SETS(SETS), .WAYS(WAYS)) u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lk_vpn   (req_vaddr[VA_W-1:OFF_W]),
    .lk_hit   (lk_hit),
    .lk_ppn   (lk_ppn),
    .fill_en  (walk_done && pt_ok),
    .fill_vpn (walk_vpn),
    .fill_ppn (pt_rd_ppn)
  );

  vt_ptab #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_ptab (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (pt_we),
    .wr_vpn   (pt_vpn),
    .wr_ppn   (pt_ppn),
    .wr_valid (pt_valid),
    .rd_vpn   (walk_vpn),
    .rd_ppn   (pt_rd_ppn),
    .rd_valid (pt_ok)
  );

  always_comb begin
    vaddr_d = vaddr_q;
    paddr_d = paddr_q;
    hit_d   = hit_q;
    fault_d = fault_q;
    if (accept) vaddr_d = req_vaddr;
    if (acc_hit) begin
      paddr_d = {lk_ppn, req_vaddr[OFF_W-1:0]};
      hit_d   = 1'b1;
      fault_d = 1'b0;
    end else if (walk_done) begin
      hit_d   = 1'b0;
      fault_d = !pt_ok;
      paddr_d = pt_ok ? {pt_rd_ppn, vaddr_q[OFF_W-1:0]} : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      paddr_q <= '0;
      hit_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      vaddr_q <= vaddr_d;
      paddr_q <= paddr_d;
      hit_q   <= hit_d;
      fault_q <= fault_d;
    end
  end

  assign rsp_paddr   = paddr_q;
  assign rsp_tlb_hit = hit_q;
  assign rsp_fault   = fault_q;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) &&
      $stable(rsp_tlb_hit) && $stable(rsp_fault))); // R10
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (!rsp_tlb_hit && rsp_paddr == '0)); // R4
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0])); // R1
endmodule

// File: tb/vtrans_top_tb.sv
`timescale 1ns/1ps
module vtrans_top_tb;
  logic        clk, rst_n;
  logic        req_valid, req_ready, rsp_valid, rsp_ready;
  logic [13:0] req_vaddr;
  logic [11:0] rsp_paddr;
  logic        rsp_tlb_hit, rsp_fault;
  logic        pt_we, pt_valid, flush;
  logic [7:0]  pt_vpn;
  logic [5:0]  pt_ppn;

  int checks = 0;
  int errors = 0;

  vtrans_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_tlb_hit(rsp_tlb_hit), .rsp_fault(rsp_fault),
    .pt_we(pt_we), .pt_vpn(pt_vpn), .pt_ppn(pt_ppn), .pt_valid(pt_valid),
    .flush(flush)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pt_write(input logic [7:0] vpn, input logic [5:0] ppn, input logic v);
    @(negedge clk);
    pt_we = 1'b1; pt_vpn = vpn; pt_ppn = ppn; pt_valid = v;
    @(negedge clk);
    pt_we = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  // One request; checks latency, fields, holding and release
  task automatic xlate(input logic [13:0] va, input int hold, input bit e_hit,
                       input bit e_fault, input logic [11:0] e_pa, input string req);
    int lat;
    logic [11:0] pa0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready when idle", int'(req_ready), 1);
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == (e_hit ? 1 : 2), e_hit ? "R2" : "R3", "latency", lat, e_hit ? 1 : 2);
    chk(rsp_tlb_hit == e_hit, req, "tlb_hit", int'(rsp_tlb_hit), int'(e_hit));
    chk(rsp_fault == e_fault, req, "fault", int'(rsp_fault), int'(e_fault));
    chk(rsp_paddr == e_pa, req, "paddr", int'(rsp_paddr), int'(e_pa));
    pa0 = rsp_paddr;
    for (int i = 0; i < hold; i++) begin
      req_valid = 1'b1;
      req_vaddr = ~va;
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == pa0, "R10", "held answer", int'(rsp_paddr), int'(pa0));
      chk(req_ready == 1'b0, "R9", "busy not ready", int'(req_ready), 0);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    if (hold > 0)
      chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R9", "released after take",
          int'(rsp_valid), 0);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R11", "req_ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R11", "rsp_valid after reset", int'(rsp_valid), 0);
  endtask

  task automatic t_miss_then_hit();
    // R3 R5 R1: VPN 0x0F -> PPN 0x0D
    xlate(14'h03D4, 0, 1'b0, 1'b0, {6'h0D, 6'h14}, "R3");
    xlate(14'h03FF, 0, 1'b1, 1'b0, {6'h0D, 6'h3F}, "R5");
  endtask

  task automatic t_fault();
    // R4: VPN 0x2E never written -> invalid
    xlate(14'h0B8F, 0, 1'b0, 1'b1, 12'h000, "R4");
    xlate(14'h0B8F, 0, 1'b0, 1'b1, 12'h000, "R4");
  endtask

  task automatic t_hold();
    // R10: VPN 0x05 -> 0x16, consumer stalls 3 cycles
    xlate(14'h0150, 3, 1'b0, 1'b0, {6'h16, 6'h10}, "R10");
    xlate(14'h0151, 2, 1'b1, 1'b0, {6'h16, 6'h11}, "R2");
  endtask

  task automatic t_stale();
    // R8: remap 0x0F, stale answer until flush (R7)
    pt_write(8'h0F, 6'h21, 1'b1);
    xlate(14'h03C0, 0, 1'b1, 1'b0, {6'h0D, 6'h00}, "R8");
    do_flush();
    xlate(14'h03C0, 0, 1'b0, 1'b0, {6'h21, 6'h00}, "R7");
    xlate(14'h03C1, 0, 1'b1, 1'b0, {6'h21, 6'h01}, "R8");
  endtask

  task automatic t_replace();
    // R6: set 0 holds VPNs 00,04,08,0C,10
    xlate({8'h00, 6'h0}, 0, 1'b0, 1'b0, {6'h28, 6'h0}, "R6");
    xlate({8'h04, 6'h0}, 0, 1'b0, 1'b0, {6'h11, 6'h0}, "R6");
    xlate({8'h08, 6'h0}, 0, 1'b0, 1'b0, {6'h13, 6'h0}, "R6");
    xlate({8'h0C, 6'h0}, 0, 1'b0, 1'b0, {6'h2A, 6'h0}, "R6");
    xlate({8'h10, 6'h0}, 0, 1'b0, 1'b0, {6'h3F, 6'h0}, "R6"); // evicts way0 (00)
    xlate({8'h04, 6'h1}, 0, 1'b1, 1'b0, {6'h11, 6'h1}, "R6");
    xlate({8'h08, 6'h1}, 0, 1'b1, 1'b0, {6'h13, 6'h1}, "R6");
    xlate({8'h0C, 6'h1}, 0, 1'b1, 1'b0, {6'h2A, 6'h1}, "R6");
    xlate({8'h10, 6'h1}, 0, 1'b1, 1'b0, {6'h3F, 6'h1}, "R6");
    xlate({8'h00, 6'h2}, 0, 1'b0, 1'b0, {6'h28, 6'h2}, "R6"); // evicts way1 (04)
    xlate({8'h04, 6'h2}, 0, 1'b0, 1'b0, {6'h11, 6'h2}, "R6"); // evicts way2 (08)
    xlate({8'h0C, 6'h2}, 0, 1'b1, 1'b0, {6'h2A, 6'h2}, "R6");
    xlate({8'h08, 6'h2}, 0, 1'b0, 1'b0, {6'h13, 6'h2}, "R6");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b0; req_vaddr = '0;
    pt_we = 1'b0; pt_vpn = '0; pt_ppn = '0; pt_valid = 1'b0; flush = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    pt_write(8'h0F, 6'h0D, 1'b1);
    pt_write(8'h05, 6'h16, 1'b1);
    pt_write(8'h00, 6'h28, 1'b1);
    pt_write(8'h04, 6'h11, 1'b1);
    pt_write(8'h08, 6'h13, 1'b1);
    pt_write(8'h0C, 6'h2A, 1'b1);
    pt_write(8'h10, 6'h3F, 1'b1);
    t_miss_then_hit();
    t_fault();
    t_hold();
    t_stale();
    t_replace();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule